// File: doc/BRIEF.md
# Pin Event Timestamp Capture Unit

This block timestamps rising edges that arrive on a set of external, asynchronous pins. Every pin is resynchronised into the core clock domain. Each capture channel is steered to one of the pins. When an armed channel sees a rising edge, it stores the time of day of one of several time domains, and it raises a sticky pending bit. The pending bits of all channels are masked by an enable register and merged into one shared interrupt line.

Software drives the block through a simple word-addressed register port. It programs each channel's configuration, reads back the stored seconds and nanoseconds, and acknowledges events by writing ones to the pending register. The time-of-day counters sit outside the block and arrive as flat input buses, one slice per domain.

Each channel runs a four-state machine:
- `ST_OFF`: disarmed, nothing pending.
- `ST_WATCH`: armed, nothing pending.
- `ST_PEND`: armed, pending.
- `ST_HOLD`: disarmed, but an earlier event is still pending.

Transitions:
- arm: OFF to WATCH, or HOLD to PEND.
- hit: any state to PEND.
- ack: PEND to WATCH, or HOLD to OFF.
- disarm: WATCH to OFF, or PEND to HOLD.
- disarm-with-ack: PEND to OFF.
- arm-with-ack: HOLD to WATCH.

Top module: `evcap_top`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low. The registers are pending, enable, each channel's configuration, and the stored seconds and nanoseconds.
- R2: Each pin passes through two synchroniser flops and one edge flop. A channel armed on pin p sees pin p driven high before clock edge k. It sets its pending bit, and stores the time, on edge k+2 and not earlier. The stored time is the value on the time inputs at edge k+2.
- R3: A falling edge, or a level held steady, causes no capture and sets no pending bit.
- R4: Channel configuration word, at word address 0x10+4*c: bits [1:0] action, [3:2] sync mode, [5:4] domain, [8:6] pin select. A channel is armed only when action is 1 (save time) and sync mode is 3. Edges on a disarmed channel are ignored: pending and stored time are unchanged.
- R5: The pin-select field picks which of the 8 pins feeds the channel. Edges on other pins have no effect on it.
- R6: The domain field d picks the time source. The seconds come from `tod_sec_i[48*d +: 48]` and the nanoseconds from `tod_ns_i[30*d +: 30]`.
- R7: The pending register is at address 0x00, with bit c for channel c. Writing 1 to a bit clears it and writing 0 leaves it unchanged. If a capture and a clear of the same bit fall on the same edge, the capture wins and the bit stays set.
- R8: The enable register is at address 0x01 and is read/write. `irq_o` is high exactly when some channel has both its pending bit and its enable bit set.
- R9: An edge on a channel whose bit is already pending overwrites the stored time, and the bit stays set.
- R10: The stored values are read at address 0x10+4*c+1 for seconds [47:32] (zero-extended), +2 for seconds [31:0], and +3 for nanoseconds (30 bits, zero-extended). The nanoseconds are stored unaltered, including the out-of-range marker values 0x3FFFFFF0 to 0x3FFFFFFF that a counter reports just before a second rolls over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 8 | Asynchronous external event pins |
| tod_sec_i | input | 192 | Seconds of the 4 time domains, 48 bits each |
| tod_ns_i | input | 120 | Nanoseconds of the 4 time domains, 30 bits each |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register word address, used for reads and writes |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Shared event interrupt |

## Verification
The bench samples the pending bit on the two edges just before the capture edge and on the capture edge itself. A design with a missing or extra synchroniser stage would therefore show the bit one cycle early or late. It times an acknowledge write to land on the same edge as a capture, and a design that let the clear win would lose that event. It also checks an overwrite while a bit is pending, a marker nanosecond value, and channels that are half-armed, mis-selected or on another domain. Wrong arming, pin steering or domain steering shows up as a stray or missing pending bit, or as a stored time that does not match the expected one.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
    localparam int PIN_SEL_W = 3;
    localparam int DOM_SEL_W = 2;
    localparam int NUM_PINS  = 1 << PIN_SEL_W;
    localparam int NUM_DOM   = 1 << DOM_SEL_W;
    localparam int SEC_W     = 48;
    localparam int NS_W      = 30;
    localparam int REG_W     = 32;

    localparam logic [1:0] ACT_SAVE = 2'd1;
    localparam logic [1:0] SYNC_ARM = 2'd3;

    localparam int REG_PEND   = 'h00;
    localparam int REG_ENABLE = 'h01;
    localparam int CH_BASE    = 'h10;
    localparam int CH_STRIDE  = 4;
    localparam int CH_CFG     = 0;
    localparam int CH_SEC_HI  = 1;
    localparam int CH_SEC_LO  = 2;
    localparam int CH_NS      = 3;

    typedef struct packed {
        logic [PIN_SEL_W-1:0] sel;
        logic [DOM_SEL_W-1:0] dom;
        logic [1:0]           sync;
        logic [1:0]           act;
    } chan_cfg_t;

    localparam int CFG_W = $bits(chan_cfg_t);

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WATCH = 2'd1,
        ST_PEND  = 2'd2,
        ST_HOLD  = 2'd3
    } chan_st_e;
endpackage

// File: rtl/evcap_sync.sv
module evcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic lvl_o,
    output logic prev_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/evcap_chan.sv
module evcap_chan
    import evcap_pkg::*;
#(
    parameter int N_PINS = NUM_PINS,
    parameter int N_DOM  = NUM_DOM,
    parameter int S_W    = SEC_W,
    parameter int N_W    = NS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  chan_cfg_t          cfg_i,
    input  logic [N_PINS-1:0]  lvl_i,
    input  logic [N_PINS-1:0]  prev_i,
    input  logic [N_DOM*S_W-1:0] tod_sec_i,
    input  logic [N_DOM*N_W-1:0] tod_ns_i,
    input  logic               clr_i,
    output logic               hit_o,
    output logic               pend_o,
    output logic [S_W-1:0]     sec_o,
    output logic [N_W-1:0]     ns_o
);
    chan_st_e        state_q, state_d;
    logic            armed, rise, hit;
    logic [S_W-1:0]  sec_q, sec_src;
    logic [N_W-1:0]  ns_q, ns_src;

    assign armed   = (cfg_i.act == ACT_SAVE) && (cfg_i.sync == SYNC_ARM);
    assign rise    = lvl_i[cfg_i.sel] & ~prev_i[cfg_i.sel];
    assign hit     = armed & rise;
    assign sec_src = tod_sec_i[int'(cfg_i.dom)*S_W +: S_W];
    assign ns_src  = tod_ns_i[int'(cfg_i.dom)*N_W +: N_W];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // transitions: arm, hit, ack, disarm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (hit)        state_d = ST_PEND;
                else if (armed) state_d = ST_WATCH;
            end
            ST_WATCH: begin
                if (hit)         state_d = ST_PEND;
                else if (!armed) state_d = ST_OFF;
            end
            ST_PEND: begin
                if (hit)         state_d = ST_PEND;
                else if (!armed) state_d = clr_i ? ST_OFF : ST_HOLD;
                else if (clr_i)  state_d = ST_WATCH;
            end
            ST_HOLD: begin
                if (hit)        state_d = ST_PEND;
                else if (armed) state_d = clr_i ? ST_WATCH : ST_PEND;
                else if (clr_i) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        pend_o = (state_q == ST_PEND) || (state_q == ST_HOLD);
        hit_o  = hit;
        sec_o  = sec_q;
        ns_o   = ns_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            ns_q  <= '0;
        end else if (hit) begin
            sec_q <= sec_src;
            ns_q  <= ns_src;
        end
    end
endmodule

// File: rtl/evcap_top.sv
module evcap_top
    import evcap_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int ADDR_W   = 8,
    parameter int SYNC_STG = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PINS-1:0]      pin_i,
    input  logic [NUM_DOM*SEC_W-1:0] tod_sec_i,
    input  logic [NUM_DOM*NS_W-1:0]  tod_ns_i,
    input  logic                     reg_wr_i,
    input  logic [ADDR_W-1:0]        reg_addr_i,
    input  logic [REG_W-1:0]         reg_wdata_i,
    output logic [REG_W-1:0]         reg_rdata_o,
    output logic                     irq_o
);
    logic [NUM_PINS-1:0]            lvl, prev;
    chan_cfg_t                      cfg_q [NUM_CH];
    logic [NUM_CH-1:0]              enable_q;
    logic [NUM_CH-1:0]              pend, cap_stb, clr_vec;
    logic [NUM_CH-1:0][SEC_W-1:0]   cap_sec;
    logic [NUM_CH-1:0][NS_W-1:0]    cap_ns;
    logic                           pend_wr, en_wr;
    logic                           unused_wdata;

    assign unused_wdata = ^reg_wdata_i;
    assign pend_wr = reg_wr_i && (reg_addr_i == ADDR_W'(REG_PEND));
    assign en_wr   = reg_wr_i && (reg_addr_i == ADDR_W'(REG_ENABLE));
    assign clr_vec = pend_wr ? reg_wdata_i[NUM_CH-1:0] : '0;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        evcap_sync #(.STAGES(SYNC_STG)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .async_i(pin_i[p]),
            .lvl_o  (lvl[p]),
            .prev_o (prev[p])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) enable_q <= '0;
        else if (en_wr) enable_q <= reg_wdata_i[NUM_CH-1:0];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int CFG_ADDR = CH_BASE + c*CH_STRIDE + CH_CFG;
        logic cfg_wr;
        assign cfg_wr = reg_wr_i && (reg_addr_i == ADDR_W'(CFG_ADDR));

        always_ff @(posedge clk) begin
            if (!rst_n) cfg_q[c] <= '0;
            else if (cfg_wr) cfg_q[c] <= chan_cfg_t'(reg_wdata_i[CFG_W-1:0]);
        end

        evcap_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_i    (cfg_q[c]),
            .lvl_i    (lvl),
            .prev_i   (prev),
            .tod_sec_i(tod_sec_i),
            .tod_ns_i (tod_ns_i),
            .clr_i    (clr_vec[c]),
            .hit_o    (cap_stb[c]),
            .pend_o   (pend[c]),
            .sec_o    (cap_sec[c]),
            .ns_o     (cap_ns[c])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_W'(REG_PEND))   reg_rdata_o = REG_W'(pend);
        if (reg_addr_i == ADDR_W'(REG_ENABLE)) reg_rdata_o = REG_W'(enable_q);
        for (int c = 0; c < NUM_CH; c++) begin
            logic [63:0] sec64;
            sec64 = 64'(cap_sec[c]);
            if (reg_addr_i == ADDR_W'(CH_BASE + c*CH_STRIDE + CH_CFG))    reg_rdata_o = REG_W'(cfg_q[c]);
            if (reg_addr_i == ADDR_W'(CH_BASE + c*CH_STRIDE + CH_SEC_HI)) reg_rdata_o = sec64[63:32];
            if (reg_addr_i == ADDR_W'(CH_BASE + c*CH_STRIDE + CH_SEC_LO)) reg_rdata_o = sec64[31:0];
            if (reg_addr_i == ADDR_W'(CH_BASE + c*CH_STRIDE + CH_NS))     reg_rdata_o = REG_W'(cap_ns[c]);
        end
    end

    assign irq_o = |(pend & enable_q);
endmodule

// File: rtl/evcap_checker.sv
module evcap_checker #(
    parameter int NUM_CH = 8,
    parameter int NS_W   = 30
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        irq_o,
    input logic                        en_wr,
    input logic [NUM_CH-1:0]           pend,
    input logic [NUM_CH-1:0]           cap_stb,
    input logic [NUM_CH-1:0]           clr_vec,
    input logic [NUM_CH-1:0][NS_W-1:0] cap_ns
);
    p_set_on_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|cap_stb) |=> ((pend & $past(cap_stb)) == $past(cap_stb)));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~cap_stb)) |=> ((pend & $past(clr_vec & ~cap_stb)) == '0));

    p_pend_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cap_stb == '0) && (clr_vec == '0)) |=> $stable(pend));

    p_capture_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_stb == '0) |=> $stable(cap_ns));

    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(|cap_stb) || $past(en_wr)));
endmodule

bind evcap_top evcap_checker #(.NUM_CH(NUM_CH), .NS_W(evcap_pkg::NS_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_o  (irq_o),
    .en_wr  (en_wr),
    .pend   (pend),
    .cap_stb(cap_stb),
    .clr_vec(clr_vec),
    .cap_ns (cap_ns)
);

// File: tb/sim_evcap_top.sv
`timescale 1ns/1ps
module sim_evcap_top;
    localparam int NCH = 8, NP = 8, ND = 4, SW = 48, NW = 30;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NP-1:0]    pin = '0;
    logic [SW-1:0]    tsec [ND];
    logic [NW-1:0]    tns  [ND];
    logic [ND*SW-1:0] tsec_flat;
    logic [ND*NW-1:0] tns_flat;
    logic             reg_wr = 1'b0;
    logic [7:0]       reg_addr = '0;
    logic [31:0]      reg_wdata = '0, reg_rdata;
    logic             irq;

    for (genvar d = 0; d < ND; d++) begin : g_tod
        assign tsec_flat[d*SW +: SW] = tsec[d];
        assign tns_flat[d*NW +: NW]  = tns[d];
    end

    evcap_top u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .tod_sec_i(tsec_flat), .tod_ns_i(tns_flat),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    int n_cmp = 0, n_bad = 0;
    logic [8:0]    m_cfg [NCH];
    logic [NCH-1:0] m_st = '0, m_en = '0;
    logic [SW-1:0] m_sec [NCH];
    logic [NW-1:0] m_ns  [NCH];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    function automatic bit armed(input int c);
        return (m_cfg[c][1:0] == 2'd1) && (m_cfg[c][3:2] == 2'd3);
    endfunction

    function automatic logic [31:0] cfg_word(input int sel, input int dom, input int sync, input int act);
        return 32'((sel << 6) | (dom << 4) | (sync << 2) | act);
    endfunction

    task automatic m_write(input logic [7:0] a, input logic [31:0] d);
        wr(a, d);
        if (a == 8'h00) m_st &= ~d[NCH-1:0];
        else if (a == 8'h01) m_en = d[NCH-1:0];
        else if (a >= 8'h10 && a < 8'h30 && a[1:0] == 2'd0) m_cfg[(a - 8'h10) >> 2] = d[8:0];
    endtask

    task automatic m_hit(input int p);
        for (int c = 0; c < NCH; c++)
            if (armed(c) && int'(m_cfg[c][8:6]) == p) begin
                m_st[c] = 1'b1;
                m_sec[c] = tsec[m_cfg[c][5:4]];
                m_ns[c]  = tns[m_cfg[c][5:4]];
            end
    endtask

    task automatic pulse(input int p);
        @(negedge clk) pin[p] = 1'b1;
        repeat (4) @(negedge clk);
        pin[p] = 1'b0;
        repeat (4) @(negedge clk);
        m_hit(p);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        logic [63:0] s64;
        rd(8'h00, d); check({tag, " R7 pending"}, d, 32'(m_st));
        rd(8'h01, d); check({tag, " R8 enable"}, d, 32'(m_en));
        check({tag, " R8 irq"}, 32'(irq), 32'(|(m_st & m_en)));
        for (int c = 0; c < NCH; c++) begin
            s64 = 64'(m_sec[c]);
            rd(8'(16 + 4*c), d);     check({tag, " R4 cfg"}, d, 32'(m_cfg[c]));
            rd(8'(16 + 4*c + 1), d); check({tag, " R10 sec hi"}, d, s64[63:32]);
            rd(8'(16 + 4*c + 2), d); check({tag, " R10 sec lo"}, d, s64[31:0]);
            rd(8'(16 + 4*c + 3), d); check({tag, " R6 ns"}, d, 32'(m_ns[c]));
        end
    endtask

    task automatic rand_tod();
        for (int d = 0; d < ND; d++) begin
            logic [31:0] a, b;
            a = $urandom(); b = $urandom();
            tsec[d] = {a[15:0], b};
            tns[d]  = NW'($urandom_range(0, 32'h3FFFFFFF));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        for (int c = 0; c < NCH; c++) begin m_cfg[c] = '0; m_sec[c] = '0; m_ns[c] = '0; end
        for (int dd = 0; dd < ND; dd++) begin tsec[dd] = 48'(dd + 1) * 48'h1_0000_0101; tns[dd] = 30'(1000 * (dd + 1)); end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_all("R1 reset");

        // R2 latency on channel 0 / pin 0 / domain 0
        m_write(8'h10, cfg_word(0, 0, 3, 1));
        m_write(8'h01, 32'h01);
        @(negedge clk) reg_addr = 8'h00; pin[0] = 1'b1;
        @(negedge clk) check("R2 after edge k", reg_rdata, 32'h0);
        @(negedge clk) check("R2 after edge k+1", reg_rdata, 32'h0);
        @(negedge clk) check("R2 after edge k+2", reg_rdata, 32'h1);
        check("R2 irq at capture", 32'(irq), 32'h1);
        m_hit(0);
        repeat (3) @(negedge clk);
        check_all("R2 capture");

        // R3 falling edge ignored after ack
        m_write(8'h00, 32'h01);
        @(negedge clk) pin[0] = 1'b0;
        repeat (6) @(negedge clk);
        check_all("R3 fall");

        // R4 half-armed channels ignore edges
        m_write(8'h14, cfg_word(1, 1, 0, 1));
        m_write(8'h18, cfg_word(2, 1, 3, 0));
        pulse(1); pulse(2);
        check_all("R4 disarmed");
        m_write(8'h14, cfg_word(1, 1, 3, 1));
        pulse(1);
        check_all("R4 armed");

        // R5 pin select: channel 2 steered to pin 5
        m_write(8'h18, cfg_word(5, 0, 3, 1));
        pulse(2);
        check_all("R5 other pin");
        pulse(5);
        check_all("R5 selected pin");

        // R6 domain 2 on channel 3
        m_write(8'h1C, cfg_word(3, 2, 3, 1));
        tsec[2] = 48'hABCD_1234_5678; tns[2] = 30'h1234567;
        pulse(3);
        check_all("R6 domain");

        // R7 write 0 no effect, then ack racing a capture
        m_write(8'h00, 32'h00);
        check_all("R7 write zero");
        m_write(8'h00, 32'h01);
        @(negedge clk) pin[0] = 1'b1;
        @(negedge clk);
        @(negedge clk) reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h01;
        @(posedge clk) #1 reg_wr = 1'b0;
        m_hit(0);
        @(negedge clk) pin[0] = 1'b0;
        repeat (4) @(negedge clk);
        check_all("R7 capture beats ack");

        // R8 masked irq
        m_write(8'h01, 32'h00);
        check_all("R8 masked");
        m_write(8'h01, 32'h02);
        check_all("R8 enabled");

        // R9 overwrite while pending, R10 marker nanoseconds
        tsec[0] = 48'hFFFF_0000_0001; tns[0] = 30'h3FFFFFF7;
        pulse(0);
        check_all("R9 R10 overwrite marker");
        rd(8'h13, d); check("R10 marker ns", d, 32'h3FFFFFF7);

        // random mix
        for (int it = 0; it < 200; it++) begin
            int op;
            op = int'($urandom_range(0, 4));
            case (op)
                0, 1: begin rand_tod(); pulse(int'($urandom_range(0, NP-1))); end
                2: m_write(8'h00, 32'($urandom_range(0, 255)));
                3: m_write(8'h01, 32'($urandom_range(0, 255)));
                default: begin
                    int c, ar;
                    c  = int'($urandom_range(0, NCH-1));
                    ar = int'($urandom_range(0, 2));
                    m_write(8'(16 + 4*c), cfg_word(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                            ar != 0 ? 3 : int'($urandom_range(0, 3)), ar != 0 ? 1 : int'($urandom_range(0, 3))));
                end
            endcase
            check_all("random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule